// File: doc/BRIEF.md
# Dual-Direction Latched/Registered Bus Transceiver

This block moves data between two ports, A and B, each a parameterised vector (18 bits by default). Every direction has three controls of its own: a latch enable, a storage clock and an output enable. With the latch enable high, the direction is transparent and its output follows its input. With the latch enable low, the direction shows the content of a storage element. That element captures the input on a falling edge of the storage clock, and keeps its value while the storage clock does not fall.

All controls are sampled on one free-running system clock. A storage-clock falling edge is found when the previous sample was 1 and the current sample is 0. Tri-state is made explicit: each port has a data-out vector and a single drive flag. The A-to-B output enable is active high and the B-to-A output enable is active low. The two directions are independent, and the block does not arbitrate when both drive at once.

Top module: `bus_xcvr`

## Requirements
- R1: While a direction's latch enable is high, its data output equals its data input in the same cycle (b_o = a_i, a_o = b_i).
- R2: While the latch enable is low and no storage-clock falling edge is detected, the data output keeps its previous value whatever the input does.
- R3: With the latch enable low, a storage clock sampled 1 and then 0 on consecutive system-clock edges captures the input present at the second of those edges. The captured value appears on the output after that edge.
- R4: b_en_o is 1 exactly when ab_oe_i is 1 (active high), in the same cycle.
- R5: a_en_o is 1 exactly when ba_oe_ni is 0 (active low), in the same cycle.
- R6: When the latch enable falls and no capture edge coincides with the fall, the output holds the input value from the last system-clock edge at which the latch enable was sampled high.
- R7: If the latch enable is high at the same edge that detects a storage-clock fall, the output stays transparent, and the stored value is that input.
- R8: While rst_ni is low, both storage elements clear to zero and the edge history clears to 0. The drive flags still follow only the output enables.
- R9: The two directions act independently. Both drive flags may be 1 together, each with its own data.
- R10: A rising edge of the storage clock, or a clock held high, captures nothing. The first sample after reset is compared against a history of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | A-port input data |
| b_i | input | W | B-port input data |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B storage clock, falling edge captures |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A storage clock, falling edge captures |
| b_o | output | W | Data presented on the B port |
| b_en_o | output | 1 | B port drive flag (0 means high impedance) |
| a_o | output | W | Data presented on the A port |
| a_en_o | output | 1 | A port drive flag (0 means high impedance) |

## Verification
Two functions can fall in the same cycle: the transparent path and a storage-clock fall capture. This happens when the storage clock is driven from 1 to 0 while the latch enable is still high. The bench provokes it in the A-to-B direction with new data on the falling sample. It judges the cycle by a transparent output, then drops the latch enable and checks that the held value is the data seen at the last latch-high edge. A second coincidence is the latch-enable fall itself against a steady storage clock. That case is judged by the output holding the last transparent value while the input moves on.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  parameter int unsigned DEF_WIDTH = 18;
  typedef enum logic {OE_HIGH = 1'b0, OE_LOW = 1'b1} oe_pol_e;
endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_i;
  end

  assign fall_o = prev_q & ~smp_i;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = bus_xcvr_pkg::DEF_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         fall_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q;
  logic         load;

  // latch enable wins over edge capture; both load the same input
  assign load = le_i | fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (load) st_q <= d_i;
  end

  assign q_o = le_i ? d_i : st_q;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W   = DEF_WIDTH,
  parameter oe_pol_e     POL = OE_HIGH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         sclk_i,
  input  logic         oe_i,
  output logic [W-1:0] q_o,
  output logic         en_o
);
  logic fall;

  xcvr_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (sclk_i),
    .fall_o (fall)
  );

  xcvr_store #(.W(W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .fall_i (fall),
    .d_i    (d_i),
    .q_o    (q_o)
  );

  generate
    if (POL == OE_LOW) begin : g_oe_low
      assign en_o = ~oe_i;
    end else begin : g_oe_high
      assign en_o = oe_i;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ab_oe_i,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  output logic [W-1:0] b_o,
  output logic         b_en_o,
  output logic [W-1:0] a_o,
  output logic         a_en_o
);
  xcvr_path #(.W(W), .POL(OE_HIGH)) u_ab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (a_i),
    .le_i   (ab_le_i),
    .sclk_i (ab_clk_i),
    .oe_i   (ab_oe_i),
    .q_o    (b_o),
    .en_o   (b_en_o)
  );

  xcvr_path #(.W(W), .POL(OE_LOW)) u_ba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (b_i),
    .le_i   (ba_le_i),
    .sclk_i (ba_clk_i),
    .oe_i   (ba_oe_ni),
    .q_o    (a_o),
    .en_o   (a_en_o)
  );
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int unsigned W = bus_xcvr_pkg::DEF_WIDTH
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         ab_oe_i,
  input logic         ab_le_i,
  input logic         ab_clk_i,
  input logic         ba_oe_ni,
  input logic         ba_le_i,
  input logic         ba_clk_i,
  input logic [W-1:0] b_o,
  input logic         b_en_o,
  input logic [W-1:0] a_o,
  input logic         a_en_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_AB_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_i |-> (b_o == a_i)); // R1
  AST_BA_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_le_i |-> (a_o == b_i)); // R1
  AST_AB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ab_le_i && !($past(ab_clk_i) && !ab_clk_i)) |=> (ab_le_i || $stable(b_o))); // R2
  AST_AB_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ab_le_i && $past(ab_clk_i) && !ab_clk_i) |=> (ab_le_i || b_o == $past(a_i))); // R3
  AST_AB_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_i |-> b_en_o); // R4
  AST_AB_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_oe_i |-> !b_en_o); // R4
  AST_BA_OE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ba_oe_ni |-> a_en_o); // R5
  AST_BA_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> !a_en_o); // R5
  AST_AB_LE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_le_i && !(seen_q && $past(ab_clk_i) && !ab_clk_i)) |=> (ab_le_i || b_o == $past(a_i))); // R6
endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .ab_oe_i  (ab_oe_i),
  .ab_le_i  (ab_le_i),
  .ab_clk_i (ab_clk_i),
  .ba_oe_ni (ba_oe_ni),
  .ba_le_i  (ba_le_i),
  .ba_clk_i (ba_clk_i),
  .b_o      (b_o),
  .b_en_o   (b_en_o),
  .a_o      (a_o),
  .a_en_o   (a_en_o)
);

// File: tb/tb_bus_xcvr.sv
`timescale 1ns/1ps
module tb_bus_xcvr;
  localparam int unsigned W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         ab_oe = 1'b0, ab_le = 1'b0, ab_clk = 1'b0;
  logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic         b_en, a_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [W-1:0] b;
    logic         ben;
    logic [W-1:0] a;
    logic         aen;
    string        tag;
  } exp_t;
  exp_t q[$];

  logic [W-1:0] st_ab = '0, st_ba = '0;
  logic         p_ab = 1'b0, p_ba = 1'b0;

  always #2.5 clk = ~clk;

  bus_xcvr #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in),
    .ab_oe_i(ab_oe), .ab_le_i(ab_le), .ab_clk_i(ab_clk),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk),
    .b_o(b_out), .b_en_o(b_en), .a_o(a_out), .a_en_o(a_en)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic aoe, input logic ale, input logic aclk,
                       input logic boen, input logic ble, input logic bclk,
                       input string tag);
    exp_t e;
    @(posedge clk);
    // model of the sampling edge, from the requirements
    if (!rst_n) begin
      st_ab = '0; st_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
    end else begin
      if (ab_le || (p_ab && !ab_clk)) st_ab = a_in;
      if (ba_le || (p_ba && !ba_clk)) st_ba = b_in;
      p_ab = ab_clk;
      p_ba = ba_clk;
    end
    #1;
    a_in = a; b_in = b;
    ab_oe = aoe; ab_le = ale; ab_clk = aclk;
    ba_oe_n = boen; ba_le = ble; ba_clk = bclk;
    e.b   = ale ? a : st_ab;
    e.ben = aoe;
    e.a   = ble ? b : st_ba;
    e.aen = !boen;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (b_out !== e.b || b_en !== e.ben || a_out !== e.a || a_en !== e.aen) begin
        n_bad++;
        $display("FAIL %s: b=%h/%b a=%h/%b expected b=%h/%b a=%h/%b",
                 e.tag, b_out, b_en, a_out, a_en, e.b, e.ben, e.a, e.aen);
      end
    end
  end

  initial begin
    // R8: in reset, storage reads zero and drive flags follow enables
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (b_out !== '0 || a_out !== '0 || b_en !== 1'b1 || a_en !== 1'b1) begin
      n_bad++;
      $display("FAIL R8: b=%h/%b a=%h/%b expected 0/1 0/1", b_out, b_en, a_out, a_en);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    drive(18'h1234, 18'h0abc, 1, 0, 0, 0, 0, 0, "R8");
    // R1 transparent
    drive(18'h2aaaa, 18'h15555, 1, 1, 0, 0, 1, 0, "R1");
    drive(18'h3ffff, 18'h00001, 1, 1, 0, 0, 1, 0, "R1");
    // R6 latch enable falls, input keeps moving
    drive(18'h00f0f, 18'h0f0f0, 1, 0, 0, 0, 0, 0, "R6");
    drive(18'h11111, 18'h22222, 1, 0, 0, 0, 0, 0, "R2");
    // R10 rising edge and held high capture nothing
    drive(18'h33333, 18'h04444, 1, 0, 1, 0, 0, 1, "R10");
    drive(18'h05555, 18'h06666, 1, 0, 1, 0, 0, 1, "R2");
    // R3 falling edge captures
    drive(18'h07777, 18'h08888, 1, 0, 0, 0, 0, 0, "R3");
    drive(18'h09999, 18'h0aaaa, 1, 0, 0, 0, 0, 0, "R3");
    drive(18'h0bbbb, 18'h0cccc, 1, 0, 0, 0, 0, 0, "R2");
    // R4 / R5 enables
    drive(18'h0bbbb, 18'h0cccc, 0, 0, 0, 1, 0, 0, "R4");
    drive(18'h0bbbb, 18'h0cccc, 1, 0, 0, 1, 0, 0, "R5");
    drive(18'h0bbbb, 18'h0cccc, 0, 0, 0, 0, 0, 0, "R5");
    // R7 fall detected while latch enable high
    drive(18'h12121, 18'h0cccc, 1, 1, 1, 0, 0, 0, "R7");
    drive(18'h34343, 18'h0cccc, 1, 1, 0, 0, 0, 0, "R7");
    drive(18'h05656, 18'h0cccc, 1, 0, 0, 0, 0, 0, "R7");
    drive(18'h07878, 18'h0cccc, 1, 0, 0, 0, 0, 0, "R7");
    // R9 independent directions, both driving
    drive(18'h1f00f, 18'h20ff0, 1, 1, 0, 0, 0, 1, "R9");
    drive(18'h1f00f, 18'h20ff0, 1, 0, 1, 0, 0, 0, "R9");
    drive(18'h00000, 18'h00000, 1, 0, 0, 0, 1, 0, "R9");
    drive(18'h00000, 18'h00000, 1, 0, 0, 0, 0, 0, "R9");
    // R3 on B-to-A with A-to-B untouched
    drive(18'h00000, 18'h3c3c3, 1, 0, 0, 0, 0, 1, "R3");
    drive(18'h00000, 18'h3c3c3, 1, 0, 0, 0, 0, 0, "R3");
    drive(18'h00000, 18'h00000, 1, 0, 0, 0, 0, 0, "R3");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule